// File: doc/BRIEF.md
# Load/Store Port Request Master

This block sits on the requesting side of a load/store port that carries one request at a time. A local user hands it a command through a valid/ready handshake. The command names a load or a store, an address, a 4-bit byte length and, for a store, the data to write. The master registers the command and then drives the port. It raises one operation strobe, presents the address with its valid flag, and follows the port's busy, address-acknowledge, address-exception and load-valid responses until the request ends.

Each request ends in one of three ways, and the port releases busy differently for each. An address exception ends the request at once. A load ends when its data-valid pulse arrives. A store sends its data for a single cycle after the address acknowledge, and then waits for the port to drop busy. In all three cases the user receives a one-cycle response pulse. The pulse carries the load data (zero otherwise) and an exception flag. A synchronous abort input returns the master to idle at any time and clears its port outputs in the same cycle.

Top module: `lsport_master`

## Requirements
- R1: While reset is high and in the first cycle after it, all port outputs are zero, `rsp_valid_o` is 0 and `cmd_ready_o` equals the inverse of `port_busy_i`.
- R2: `cmd_ready_o` is 1 only when no request is in flight, `port_busy_i` is 0 and `abort_i` is 0. A command offered while it is 0 is not taken, and no port strobe follows.
- R3: From the cycle after acceptance until the request ends, exactly one of `port_load_o`/`port_store_o` is 1, matching the command (store strobe when `cmd_is_store_i` was 1). `port_addr_valid_o` is 1 in the same cycles, and `port_addr_o` holds the accepted address unchanged.
- R4: An address-exception pulse received while waiting for the address acknowledge ends the request. In the next cycle `rsp_valid_o`=1, `rsp_exc_o`=1, `rsp_rdata_o`=0, every port strobe is 0, and `port_wvalid_o` never rose.
- R5: For a load, a `port_rvalid_i` pulse after the address acknowledge gives a response in the next cycle: `rsp_valid_o`=1, `rsp_exc_o`=0, and `rsp_rdata_o` equals the `port_rdata_i` value of that pulse cycle. A `port_rvalid_i` pulse before the acknowledge is ignored.
- R6: For a store, `port_wvalid_o` is 1 for exactly one cycle, the cycle right after the address-acknowledge pulse. In that cycle it carries the accepted store data on `port_wdata_o`, and it is never 1 before the acknowledge.
- R7: After the store data cycle, the strobe and address stay asserted until `port_busy_i` is seen low. In the cycle after that, `rsp_valid_o`=1, `rsp_exc_o`=0 and `rsp_rdata_o`=0.
- R8: In any cycle with `abort_i`=1, all port outputs and `cmd_ready_o` are 0. The following cycle is idle and carries no response.
- R9: `port_len_o` equals the accepted length while the request is active, and is 0 otherwise.
- R10: `rsp_valid_o` is never 1 for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| abort_i | input | 1 | Synchronous abort, returns to idle |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Command can be taken this cycle |
| cmd_is_store_i | input | 1 | 1 = store, 0 = load |
| cmd_addr_i | input | ADDR_W | Command address |
| cmd_len_i | input | LEN_W | Byte length |
| cmd_wdata_i | input | DATA_W | Store data |
| rsp_valid_o | output | 1 | One-cycle response pulse |
| rsp_exc_o | output | 1 | Request ended in address exception |
| rsp_rdata_o | output | DATA_W | Load data, zero for store/exception |
| port_load_o | output | 1 | Load strobe to port |
| port_store_o | output | 1 | Store strobe to port |
| port_len_o | output | LEN_W | Length to port |
| port_addr_valid_o | output | 1 | Address valid to port |
| port_addr_o | output | ADDR_W | Address to port |
| port_wvalid_o | output | 1 | Store data valid to port |
| port_wdata_o | output | DATA_W | Store data to port |
| port_busy_i | input | 1 | Port busy |
| port_addr_ack_i | input | 1 | Address acknowledge pulse |
| port_addr_exc_i | input | 1 | Address exception pulse |
| port_rvalid_i | input | 1 | Load data valid pulse |
| port_rdata_i | input | DATA_W | Load data |

## Verification
The bench goes after three timing corners.
- A store must release its data exactly one cycle after the acknowledge and then wait out busy. A design that sends data early, holds it for two cycles, or answers before busy falls fails the store checks.
- A load-valid pulse that arrives before the acknowledge must be dropped. A design that takes it would return a false response with stray data.
- An exception must end the request with an exception response and no data phase. An abort in mid-request must clear every port output in the same cycle. A design that lets either case leak a response or a strobe is caught at the ports.

// File: rtl/lsport_pkg.sv
package lsport_pkg;

    localparam int LEN_W_DEF = 4;

    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_ADDR    = 3'd1,
        S_LDWAIT  = 3'd2,
        S_STDATA  = 3'd3,
        S_STDRAIN = 3'd4
    } lsp_state_e;

    typedef enum logic [1:0] {
        END_NONE  = 2'd0,
        END_LOAD  = 2'd1,
        END_STORE = 2'd2,
        END_EXC   = 2'd3
    } lsp_end_e;

    function automatic logic in_flight(lsp_state_e s);
        return s != S_IDLE;
    endfunction

endpackage

// File: rtl/lsport_cmd_hold.sv
module lsport_cmd_hold #(
    parameter int ADDR_W = 48,
    parameter int DATA_W = 64,
    parameter int LEN_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic              is_store_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              is_store_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [LEN_W-1:0]  len_q,
    output logic [DATA_W-1:0] wdata_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            is_store_q <= 1'b0;
            addr_q     <= '0;
            len_q      <= '0;
            wdata_q    <= '0;
        end else if (load_i) begin
            is_store_q <= is_store_i;
            addr_q     <= addr_i;
            len_q      <= len_i;
            wdata_q    <= wdata_i;
        end
    end
endmodule

// File: rtl/lsport_ctrl.sv
module lsport_ctrl
    import lsport_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       abort_i,
    input  logic       cmd_valid_i,
    input  logic       is_store_q_i,
    input  logic       busy_i,
    input  logic       ack_i,
    input  logic       exc_i,
    input  logic       rvalid_i,
    output lsp_state_e state_o,
    output logic       accept_o,
    output lsp_end_e   end_o
);
    lsp_state_e state_q, state_d;

    assign accept_o = (state_q == S_IDLE) && !busy_i && !abort_i && cmd_valid_i;

    always_comb begin
        end_o = END_NONE;
        if (!abort_i) begin
            case (state_q)
                S_ADDR:    if (exc_i)    end_o = END_EXC;
                S_LDWAIT:  if (rvalid_i) end_o = END_LOAD;
                S_STDRAIN: if (!busy_i)  end_o = END_STORE;
                default:   end_o = END_NONE;
            endcase
        end
    end

    always_comb begin
        state_d = state_q;
        if (abort_i) begin
            state_d = S_IDLE;
        end else begin
            case (state_q)
                S_IDLE:    if (accept_o) state_d = S_ADDR;
                S_ADDR: begin
                    if (exc_i)      state_d = S_IDLE;
                    else if (ack_i) state_d = is_store_q_i ? S_STDATA : S_LDWAIT;
                end
                S_LDWAIT:  if (rvalid_i) state_d = S_IDLE;
                S_STDATA:  state_d = S_STDRAIN;
                S_STDRAIN: if (!busy_i) state_d = S_IDLE;
                default:   state_d = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= state_d;
    end

    assign state_o = state_q;
endmodule

// File: rtl/lsport_resp.sv
module lsport_resp
    import lsport_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  lsp_end_e          end_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              rsp_valid_o,
    output logic              rsp_exc_o,
    output logic [DATA_W-1:0] rsp_rdata_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_o <= 1'b0;
            rsp_exc_o   <= 1'b0;
            rsp_rdata_o <= '0;
        end else begin
            rsp_valid_o <= (end_i != END_NONE);
            rsp_exc_o   <= (end_i == END_EXC);
            rsp_rdata_o <= (end_i == END_LOAD) ? rdata_i : '0;
        end
    end
endmodule

// File: rtl/lsport_master.sv
module lsport_master
    import lsport_pkg::*;
#(
    parameter int ADDR_W     = 48,
    parameter int DATA_W     = 64,
    parameter int LEN_W      = LEN_W_DEF,
    parameter bit BLANK_IDLE = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              abort_i,
    input  logic              cmd_valid_i,
    output logic              cmd_ready_o,
    input  logic              cmd_is_store_i,
    input  logic [ADDR_W-1:0] cmd_addr_i,
    input  logic [LEN_W-1:0]  cmd_len_i,
    input  logic [DATA_W-1:0] cmd_wdata_i,
    output logic              rsp_valid_o,
    output logic              rsp_exc_o,
    output logic [DATA_W-1:0] rsp_rdata_o,
    output logic              port_load_o,
    output logic              port_store_o,
    output logic [LEN_W-1:0]  port_len_o,
    output logic              port_addr_valid_o,
    output logic [ADDR_W-1:0] port_addr_o,
    output logic              port_wvalid_o,
    output logic [DATA_W-1:0] port_wdata_o,
    input  logic              port_busy_i,
    input  logic              port_addr_ack_i,
    input  logic              port_addr_exc_i,
    input  logic              port_rvalid_i,
    input  logic [DATA_W-1:0] port_rdata_i
);
    lsp_state_e        st_q;
    lsp_end_e          end_w;
    logic              accept_w;
    logic              is_store_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  len_q;
    logic [DATA_W-1:0] wdata_q;
    logic              active_w;

    lsport_cmd_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_hold (
        .clk(clk), .rst(rst), .load_i(accept_w),
        .is_store_i(cmd_is_store_i), .addr_i(cmd_addr_i), .len_i(cmd_len_i),
        .wdata_i(cmd_wdata_i), .is_store_q(is_store_q), .addr_q(addr_q),
        .len_q(len_q), .wdata_q(wdata_q)
    );

    lsport_ctrl u_ctrl (
        .clk(clk), .rst(rst), .abort_i(abort_i), .cmd_valid_i(cmd_valid_i),
        .is_store_q_i(is_store_q), .busy_i(port_busy_i), .ack_i(port_addr_ack_i),
        .exc_i(port_addr_exc_i), .rvalid_i(port_rvalid_i),
        .state_o(st_q), .accept_o(accept_w), .end_o(end_w)
    );

    lsport_resp #(.DATA_W(DATA_W)) u_resp (
        .clk(clk), .rst(rst), .end_i(end_w), .rdata_i(port_rdata_i),
        .rsp_valid_o(rsp_valid_o), .rsp_exc_o(rsp_exc_o), .rsp_rdata_o(rsp_rdata_o)
    );

    assign active_w          = in_flight(st_q) && !abort_i;
    assign cmd_ready_o       = (st_q == S_IDLE) && !port_busy_i && !abort_i;
    assign port_load_o       = active_w && !is_store_q;
    assign port_store_o      = active_w && is_store_q;
    assign port_addr_valid_o = active_w;
    assign port_wvalid_o     = (st_q == S_STDATA) && !abort_i;

    generate
        if (BLANK_IDLE) begin : g_blank
            assign port_addr_o  = active_w ? addr_q : '0;
            assign port_len_o   = active_w ? len_q : '0;
            assign port_wdata_o = port_wvalid_o ? wdata_q : '0;
        end else begin : g_raw
            assign port_addr_o  = addr_q;
            assign port_len_o   = active_w ? len_q : '0;
            assign port_wdata_o = wdata_q;
        end
    endgenerate
endmodule

// File: rtl/lsport_master_chk.sv
module lsport_master_chk
    import lsport_pkg::*;
#(
    parameter int ADDR_W = 48
) (
    input logic              clk,
    input logic              rst,
    input logic              abort_i,
    input logic              cmd_ready_o,
    input logic              rsp_valid_o,
    input logic              rsp_exc_o,
    input logic              port_load_o,
    input logic              port_store_o,
    input logic              port_addr_valid_o,
    input logic [ADDR_W-1:0] port_addr_o,
    input logic              port_wvalid_o,
    input logic              port_busy_i,
    input logic              port_addr_ack_i,
    input logic              port_addr_exc_i,
    input lsp_state_e        st_q
);
    // R2
    ready_busy_chk: assert property (@(posedge clk) disable iff (rst)
        port_busy_i |-> !cmd_ready_o);
    // R3
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(port_load_o && port_store_o));
    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (port_addr_valid_o && $past(port_addr_valid_o)) |-> $stable(port_addr_o));
    // R4
    exc_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_ADDR && port_addr_exc_i && !abort_i) |=> (rsp_valid_o && rsp_exc_o));
    // R6
    wvalid_single_chk: assert property (@(posedge clk) disable iff (rst)
        port_wvalid_o |=> !port_wvalid_o);
    // R6
    wvalid_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
        port_wvalid_o |-> ($past(port_addr_ack_i) && port_store_o));
    // R8
    abort_drop_chk: assert property (@(posedge clk) disable iff (rst)
        abort_i |-> !(port_load_o || port_store_o || port_addr_valid_o
                      || port_wvalid_o || cmd_ready_o));
    // R10
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid_o |=> !rsp_valid_o);
endmodule

bind lsport_master lsport_master_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .abort_i(abort_i), .cmd_ready_o(cmd_ready_o),
    .rsp_valid_o(rsp_valid_o), .rsp_exc_o(rsp_exc_o),
    .port_load_o(port_load_o), .port_store_o(port_store_o),
    .port_addr_valid_o(port_addr_valid_o), .port_addr_o(port_addr_o),
    .port_wvalid_o(port_wvalid_o), .port_busy_i(port_busy_i),
    .port_addr_ack_i(port_addr_ack_i), .port_addr_exc_i(port_addr_exc_i),
    .st_q(st_q)
);

// File: tb/lsport_master_test.sv
module lsport_master_test;
    localparam int AW = 48;
    localparam int DW = 64;
    localparam int LW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic abort_i = 0, cmd_valid_i = 0, cmd_is_store_i = 0;
    logic [AW-1:0] cmd_addr_i = '0;
    logic [LW-1:0] cmd_len_i = '0;
    logic [DW-1:0] cmd_wdata_i = '0;
    logic cmd_ready_o, rsp_valid_o, rsp_exc_o;
    logic [DW-1:0] rsp_rdata_o;
    logic port_load_o, port_store_o, port_addr_valid_o, port_wvalid_o;
    logic [LW-1:0] port_len_o;
    logic [AW-1:0] port_addr_o;
    logic [DW-1:0] port_wdata_o;
    logic port_busy_i = 0, port_addr_ack_i = 0, port_addr_exc_i = 0, port_rvalid_i = 0;
    logic [DW-1:0] port_rdata_i = '0;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    lsport_master uut (.*);

    typedef struct packed {
        logic          st;
        logic          exc;
        logic [AW-1:0] addr;
        logic [LW-1:0] len;
        logic [DW-1:0] wd;
        logic [DW-1:0] rd;
        logic [3:0]    ack_dly;
        logic [3:0]    rd_dly;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 1'b0, 48'h0000_1234_5678, 4'h8, 64'h0, 64'hDEAD_BEEF_0123_4567, 4'd0, 4'd0},
        '{1'b1, 1'b0, 48'hABCD_0000_0010, 4'h4, 64'hCAFE_F00D_1111_2222, 64'h0, 4'd2, 4'd0},
        '{1'b0, 1'b1, 48'hFFFF_FFFF_FFF8, 4'h1, 64'h0, 64'h0, 4'd1, 4'd0},
        '{1'b0, 1'b0, 48'h0000_0000_0008, 4'h2, 64'h0, 64'h0000_0000_0000_A5A5, 4'd3, 4'd4},
        '{1'b1, 1'b1, 48'h8000_0000_0000, 4'hF, 64'h5555_AAAA_5555_AAAA, 64'h0, 4'd0, 4'd0},
        '{1'b1, 1'b0, 48'h0000_0000_0001, 4'h1, 64'h0000_0000_0000_00FF, 64'h0, 4'd0, 4'd0}
    };

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_req(input vec_t v);
        @(negedge clk);
        cmd_valid_i = 1; cmd_is_store_i = v.st; cmd_addr_i = v.addr;
        cmd_len_i = v.len; cmd_wdata_i = v.wd;
        #1 chk(cmd_ready_o == 1'b1, "R2 ready idle", 64'(cmd_ready_o), 64'd1);
        @(negedge clk);
        cmd_valid_i = 0;
        chk(port_load_o == !v.st && port_store_o == v.st, "R3 strobe",
            64'({port_load_o, port_store_o}), 64'({!v.st, v.st}));
        chk(port_addr_valid_o && port_addr_o == v.addr, "R3 addr",
            64'(port_addr_o), 64'(v.addr));
        chk(port_len_o == v.len, "R9 len", 64'(port_len_o), 64'(v.len));
        port_busy_i = 1;
        for (int i = 0; i < int'(v.ack_dly); i++) begin
            @(negedge clk);
            chk(port_addr_o == v.addr && !port_wvalid_o && !cmd_ready_o,
                "R6 wait ack", 64'(port_wvalid_o), 64'd0);
        end
        if (v.exc) begin
            port_addr_exc_i = 1; port_busy_i = 0;
        end else begin
            port_addr_ack_i = 1;
        end
        @(negedge clk);
        port_addr_exc_i = 0; port_addr_ack_i = 0;
        if (v.exc) begin
            chk(rsp_valid_o && rsp_exc_o && rsp_rdata_o == '0, "R4 exc rsp",
                64'({rsp_valid_o, rsp_exc_o}), 64'd3);
            chk(!port_addr_valid_o && !port_load_o && !port_store_o && !port_wvalid_o,
                "R4 strobes off", 64'(port_addr_valid_o), 64'd0);
        end else if (!v.st) begin
            chk(!port_wvalid_o && !rsp_valid_o && port_load_o, "R5 wait data",
                64'(rsp_valid_o), 64'd0);
            for (int i = 0; i < int'(v.rd_dly); i++) begin
                @(negedge clk);
                chk(!rsp_valid_o && port_addr_o == v.addr, "R5 hold",
                    64'(rsp_valid_o), 64'd0);
            end
            port_rvalid_i = 1; port_rdata_i = v.rd; port_busy_i = 0;
            @(negedge clk);
            port_rvalid_i = 0; port_rdata_i = '1;
            chk(rsp_valid_o && !rsp_exc_o && rsp_rdata_o == v.rd, "R5 load data",
                rsp_rdata_o, v.rd);
            chk(!port_addr_valid_o && port_len_o == '0, "R9 len idle",
                64'(port_len_o), 64'd0);
        end else begin
            chk(port_wvalid_o && port_wdata_o == v.wd, "R6 store data",
                port_wdata_o, v.wd);
            @(negedge clk);
            chk(!port_wvalid_o, "R6 single beat", 64'(port_wvalid_o), 64'd0);
            chk(port_addr_valid_o && port_store_o && !rsp_valid_o, "R7 held",
                64'(port_addr_valid_o), 64'd1);
            port_busy_i = 0;
            @(negedge clk);
            chk(rsp_valid_o && !rsp_exc_o && rsp_rdata_o == '0, "R7 store rsp",
                64'({rsp_valid_o, rsp_exc_o}), 64'd2);
        end
        @(negedge clk);
        chk(!rsp_valid_o, "R10 pulse", 64'(rsp_valid_o), 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!port_load_o && !port_store_o && !port_addr_valid_o && !port_wvalid_o
            && port_addr_o == '0 && !rsp_valid_o, "R1 reset outputs",
            64'(port_addr_valid_o), 64'd0);
        rst = 0;
        @(negedge clk);
        chk(cmd_ready_o && !rsp_valid_o, "R1 after reset", 64'(cmd_ready_o), 64'd1);

        foreach (VECS[k]) do_req(VECS[k]);

        // R2: busy high while idle blocks acceptance
        @(negedge clk);
        port_busy_i = 1; cmd_valid_i = 1; cmd_is_store_i = 0; cmd_addr_i = 48'h77;
        #1 chk(!cmd_ready_o, "R2 busy blocks", 64'(cmd_ready_o), 64'd0);
        @(negedge clk);
        cmd_valid_i = 0; port_busy_i = 0;
        chk(!port_load_o && !port_addr_valid_o, "R2 no strobe",
            64'(port_addr_valid_o), 64'd0);

        // R5: data pulse before acknowledge is ignored
        @(negedge clk);
        cmd_valid_i = 1; cmd_is_store_i = 0; cmd_addr_i = 48'h40; cmd_len_i = 4'h8;
        @(negedge clk);
        cmd_valid_i = 0; port_busy_i = 1;
        port_rvalid_i = 1; port_rdata_i = 64'h1111;
        @(negedge clk);
        port_rvalid_i = 0;
        chk(!rsp_valid_o && port_load_o, "R5 early data ignored",
            64'(rsp_valid_o), 64'd0);
        port_addr_ack_i = 1;
        @(negedge clk);
        port_addr_ack_i = 0;
        port_rvalid_i = 1; port_rdata_i = 64'h2222; port_busy_i = 0;
        @(negedge clk);
        port_rvalid_i = 0;
        chk(rsp_valid_o && rsp_rdata_o == 64'h2222, "R5 late data",
            rsp_rdata_o, 64'h2222);

        // R8: abort mid-request
        @(negedge clk);
        cmd_valid_i = 1; cmd_is_store_i = 1; cmd_addr_i = 48'h99; cmd_wdata_i = 64'h5;
        @(negedge clk);
        cmd_valid_i = 0; port_busy_i = 1;
        port_addr_ack_i = 1;
        @(negedge clk);
        port_addr_ack_i = 0;
        abort_i = 1;
        #1 chk(!port_wvalid_o && !port_store_o && !port_addr_valid_o && !cmd_ready_o,
               "R8 abort drops", 64'(port_wvalid_o), 64'd0);
        @(negedge clk);
        abort_i = 0; port_busy_i = 0;
        #1 chk(!rsp_valid_o && cmd_ready_o && !port_wvalid_o && !port_addr_valid_o,
               "R8 idle after abort", 64'(rsp_valid_o), 64'd0);
        @(negedge clk);
        chk(!rsp_valid_o, "R8 no response", 64'(rsp_valid_o), 64'd0);

        do_req(VECS[1]);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule